// File: doc/BRIEF.md
# Strap Capture and Frequency Code Selector

This block sits beside a clock generator's configuration logic. Five package pins have two jobs. While power-on reset is held, they are inputs, and the block stores their levels as board straps. Once reset ends, the same pins carry clocks. The block decides when those pins may start to drive, and it holds the captured straps for the rest of the power cycle.

From the straps and one configuration byte, the block produces the 5-bit frequency code that the synthesizer uses. A source bit in the byte picks the code: the captured straps, or a software field packed into the same byte. Because the byte resets to zero, the straps set the frequency after power-up. The byte also carries a spread-spectrum enable and a global output-off bit, which the block passes on. The captured straps are offered in inverted form on three readback fields for the serial register map.

Top module: `fsel_strap_ctrl`

## Requirements
- R1: On every rising clock edge at which `por_n` is low, the strap latch loads `pin_in`. Bit i of `pin_in`, of the latch and of `fsel_code` all stand for select line FSi.
- R2: On edges at which `por_n` is high, the latch keeps its value, so pin changes after release do not alter `fsel_code` when straps are the source, nor the readback fields.
- R3: `pin_oe` is all zeros on the edge after any edge that samples `por_n` low. It stays zero after the first edge that samples `por_n` high. It becomes all ones (output-off bit clear) after HOLD_CYCLES+1 edges with `por_n` high.
- R4: `cfg_byte0` bit 3 picks the code source. With 0, `fsel_code` equals the latched straps and the register field is ignored. With 1, `fsel_code` = {bit2, bit7, bit6, bit5, bit4} of `cfg_byte0`, that is FS4 = bit2, FS3 = bit7, FS2 = bit6, FS1 = bit5, FS0 = bit4.
- R5: Readback is the inverse of the latch: `rd_fs0_n` = ~FS0; `rd_fs21_n` = {~FS2, ~FS1}; `rd_fs43_n` = {~FS4, ~FS3}.
- R6: `spread_en` follows `cfg_byte0` bit 1. While `cfg_byte0` bit 0 is set, `tristate_all` is 1 and `pin_oe` is all zeros, and clearing it restores the enables.
- R7: With `cfg_byte0` at its reset value of zero, `fsel_code` equals the latched straps.
- R8: Asserting `por_n` again drops `pin_oe`, captures the new pin levels, and repeats the R3 release sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, sampled on the clock |
| pin_in | input | 5 | Levels seen on the shared select pins |
| cfg_byte0 | input | 8 | Configuration byte: source, spread, output-off, code field |
| pin_oe | output | 5 | Output enables for the shared pins |
| fsel_code | output | 5 | Active frequency code, bit i = FSi |
| spread_en | output | 1 | Spread-spectrum enable |
| tristate_all | output | 1 | All clock outputs to be floated |
| rd_fs0_n | output | 1 | Inverted latched FS0 |
| rd_fs21_n | output | 2 | Inverted latched {FS2, FS1} |
| rd_fs43_n | output | 2 | Inverted latched {FS4, FS3} |

## Verification
A latch that keeps loading after release shows at once in the readback fields and in the strap-sourced code. The bench moves the pins on the same cycle that reset is released, so such a fault appears on the very next edge. An off-by-one in the release counter shows as `pin_oe` rising one edge early or late. The bench samples `pin_oe` on each of the first two edges after release. A swapped field bit or a wrong readback polarity is exposed by asymmetric codes and strap patterns, checked in the same cycle as the byte changes.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
   localparam int FS_W = 5;
   typedef logic [FS_W-1:0] fs_code_t;

   // control bit positions inside configuration byte 0
   localparam int B0_TRI    = 0;
   localparam int B0_SPREAD = 1;
   localparam int B0_SRC    = 3;

   // software code field: FS4 at bit 2, FS3..FS0 at bits 7..4
   function automatic fs_code_t cfg_code_field(input logic [7:0] b);
      return {b[2], b[7], b[6], b[5], b[4]};
   endfunction
endpackage

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic [W-1:0] pin_in,
   output logic [W-1:0] strap_q
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic q;
      // open only while reset is held, frozen afterwards
      always_ff @(posedge clk) begin
         if (!por_n) q <= pin_in[i];
      end
      assign strap_q[i] = q;
   end
endmodule

// File: rtl/fsel_oe_seq.sv
module fsel_oe_seq #(
   parameter int W           = 5,
   parameter int HOLD_CYCLES = 1
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         tri_all,
   output logic [W-1:0] pin_oe
);
   localparam int LIM = HOLD_CYCLES + 1;
   localparam int CW  = $clog2(LIM + 1);
   localparam logic [CW-1:0] LIM_C = CW'(LIM);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!por_n)            cnt <= '0;
      else if (cnt != LIM_C) cnt <= cnt + 1'b1;
   end

   logic drive_ok;
   assign drive_ok = (cnt == LIM_C) && !tri_all;
   assign pin_oe   = {W{drive_ok}};
endmodule

// File: rtl/fsel_src_mux.sv
module fsel_src_mux #(
   parameter int W        = 5,
   parameter int CODE_REG = 0
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         use_reg,
   input  logic [W-1:0] strap,
   input  logic [W-1:0] reg_field,
   output logic [W-1:0] code
);
   logic [W-1:0] pick;
   assign pick = use_reg ? reg_field : strap;

   if (CODE_REG != 0) begin : g_reg
      logic [W-1:0] code_q;
      always_ff @(posedge clk) begin
         if (!por_n) code_q <= strap;
         else        code_q <= pick;
      end
      assign code = code_q;
   end else begin : g_comb
      assign code = pick;
   end
endmodule

// File: rtl/fsel_strap_ctrl.sv
module fsel_strap_ctrl
   import fsel_pkg::*;
#(
   parameter int NUM_SEL     = 5,
   parameter int HOLD_CYCLES = 1,
   parameter int CODE_REG    = 0
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic [4:0]   pin_in,
   input  logic [7:0]   cfg_byte0,
   output logic [4:0]   pin_oe,
   output logic [4:0]   fsel_code,
   output logic         spread_en,
   output logic         tristate_all,
   output logic         rd_fs0_n,
   output logic [1:0]   rd_fs21_n,
   output logic [1:0]   rd_fs43_n
);
   if (NUM_SEL != FS_W) begin : g_bad_w
      $error("NUM_SEL must equal the packed code width");
   end
   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("HOLD_CYCLES must be at least 1");
   end
   if (CODE_REG != 0 && CODE_REG != 1) begin : g_bad_reg
      $error("CODE_REG must be 0 or 1");
   end

   fs_code_t strap;

   fsel_strap_latch #(.W(NUM_SEL)) u_latch (
      .clk     (clk),
      .por_n   (por_n),
      .pin_in  (pin_in),
      .strap_q (strap)
   );

   fsel_oe_seq #(.W(NUM_SEL), .HOLD_CYCLES(HOLD_CYCLES)) u_oe (
      .clk     (clk),
      .por_n   (por_n),
      .tri_all (cfg_byte0[B0_TRI]),
      .pin_oe  (pin_oe)
   );

   fsel_src_mux #(.W(NUM_SEL), .CODE_REG(CODE_REG)) u_mux (
      .clk       (clk),
      .por_n     (por_n),
      .use_reg   (cfg_byte0[B0_SRC]),
      .strap     (strap),
      .reg_field (cfg_code_field(cfg_byte0)),
      .code      (fsel_code)
   );

   assign spread_en    = cfg_byte0[B0_SPREAD];
   assign tristate_all = cfg_byte0[B0_TRI];

   assign rd_fs0_n  = ~strap[0];
   assign rd_fs21_n = ~{strap[2], strap[1]};
   assign rd_fs43_n = ~{strap[4], strap[3]};
endmodule

// File: rtl/fsel_strap_ctrl_chk.sv
module fsel_strap_ctrl_chk (
   input logic       clk,
   input logic       por_n,
   input logic [4:0] pin_in,
   input logic [7:0] cfg_byte0,
   input logic [4:0] pin_oe,
   input logic [4:0] fsel_code,
   input logic       spread_en,
   input logic       tristate_all,
   input logic       rd_fs0_n,
   input logic [1:0] rd_fs21_n,
   input logic [1:0] rd_fs43_n
);
   // R2: latched straps never move while reset is released
   a_r2_latch_hold: assert property (@(posedge clk) disable iff (!por_n)
      1'b1 |=> ($stable(rd_fs0_n) && $stable(rd_fs21_n) && $stable(rd_fs43_n)));

   // R3 / R8: enables drop after any reset sample
   a_r3_oe_off_in_reset: assert property (@(posedge clk)
      !por_n |=> (pin_oe == 5'b0));

   // R3: one full clock of silence after release
   a_r3_oe_gap: assert property (@(posedge clk) disable iff (!por_n)
      $rose(por_n) |=> (pin_oe == 5'b0));

   // R4: software field mapping
   a_r4_reg_field: assert property (@(posedge clk) disable iff (!por_n)
      cfg_byte0[3] |-> (fsel_code[4] == cfg_byte0[2] && fsel_code[0] == cfg_byte0[4]));

   // R5: strap-sourced code and readback are complements
   a_r5_readback_inv: assert property (@(posedge clk) disable iff (!por_n)
      !cfg_byte0[3] |-> (rd_fs0_n != fsel_code[0] && rd_fs43_n[1] != fsel_code[4]));

   // R6: output-off bit forces enables low
   a_r6_tristate: assert property (@(posedge clk) disable iff (!por_n)
      cfg_byte0[0] |-> (pin_oe == 5'b0 && tristate_all));
endmodule

bind fsel_strap_ctrl fsel_strap_ctrl_chk u_chk (.*);

// File: tb/tb_fsel_strap_ctrl.sv
module tb_fsel_strap_ctrl;
   logic       clk = 1'b0;
   logic       por_n;
   logic [4:0] pin_in;
   logic [7:0] cfg_byte0;
   logic [4:0] pin_oe;
   logic [4:0] fsel_code;
   logic       spread_en;
   logic       tristate_all;
   logic       rd_fs0_n;
   logic [1:0] rd_fs21_n;
   logic [1:0] rd_fs43_n;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   fsel_strap_ctrl dut (
      .clk(clk), .por_n(por_n), .pin_in(pin_in), .cfg_byte0(cfg_byte0),
      .pin_oe(pin_oe), .fsel_code(fsel_code), .spread_en(spread_en),
      .tristate_all(tristate_all), .rd_fs0_n(rd_fs0_n),
      .rd_fs21_n(rd_fs21_n), .rd_fs43_n(rd_fs43_n)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_rb(input string tag, input logic [4:0] s);
      chk(tag, {3'b0, rd_fs0_n, rd_fs21_n, rd_fs43_n},
          {3'b0, ~s[0], ~s[2], ~s[1], ~s[4], ~s[3]});
   endtask

   // R1 R7 R5 R3: capture under reset with default byte
   task automatic t_capture(input logic [4:0] pat);
      por_n = 1'b0; pin_in = pat; cfg_byte0 = 8'h00;
      repeat (3) @(negedge clk);
      chk("R3 oe low in reset", {3'b0, pin_oe}, 8'h00);
      chk("R1/R7 code from straps", {3'b0, fsel_code}, {3'b0, pat});
      chk_rb("R5 readback inverted", pat);
   endtask

   // R2 R3: release, pins move at once, latch holds, oe gap
   task automatic t_release(input logic [4:0] held, input logic [4:0] moved);
      por_n = 1'b1; pin_in = moved;
      @(negedge clk);
      chk("R3 oe still low first edge", {3'b0, pin_oe}, 8'h00);
      chk("R2 latch frozen", {3'b0, fsel_code}, {3'b0, held});
      @(negedge clk);
      chk("R3 oe high second edge", {3'b0, pin_oe}, 8'h1F);
      repeat (4) @(negedge clk);
      chk("R2 latch frozen later", {3'b0, fsel_code}, {3'b0, held});
      chk_rb("R2/R5 readback frozen", held);
   endtask

   // R4: software source with asymmetric patterns, then field ignored
   task automatic t_reg_source(input logic [4:0] held);
      logic [7:0] pats [4] = '{8'h08, 8'hF8, 8'h0C, 8'hA8};
      for (int k = 0; k < 4; k++) begin
         cfg_byte0 = pats[k];
         #1;
         chk("R4 register field", {3'b0, fsel_code},
             {3'b0, pats[k][2], pats[k][7], pats[k][6], pats[k][5], pats[k][4]});
      end
      cfg_byte0 = 8'hF4;
      #1;
      chk("R4 field ignored when source=0", {3'b0, fsel_code}, {3'b0, held});
      @(negedge clk);
   endtask

   // R6: spread and output-off
   task automatic t_ctrl_bits();
      cfg_byte0 = 8'h02; #1;
      chk("R6 spread on", {7'b0, spread_en}, 8'h01);
      chk("R6 oe with spread", {3'b0, pin_oe}, 8'h1F);
      cfg_byte0 = 8'h01; #1;
      chk("R6 tristate flag", {6'b0, tristate_all, spread_en}, 8'h02);
      chk("R6 oe forced low", {3'b0, pin_oe}, 8'h00);
      cfg_byte0 = 8'h00; #1;
      chk("R6 oe restored", {3'b0, pin_oe}, 8'h1F);
      @(negedge clk);
   endtask

   // R8: second reset recaptures
   task automatic t_recapture(input logic [4:0] pat);
      por_n = 1'b0; pin_in = pat;
      @(negedge clk);
      chk("R8 oe dropped", {3'b0, pin_oe}, 8'h00);
      chk("R8 new strap", {3'b0, fsel_code}, {3'b0, pat});
      chk_rb("R8 readback new", pat);
      por_n = 1'b1; pin_in = ~pat;
      @(negedge clk);
      chk("R8 gap repeated", {3'b0, pin_oe}, 8'h00);
      @(negedge clk);
      chk("R8 oe back", {3'b0, pin_oe}, 8'h1F);
      chk("R8 strap held", {3'b0, fsel_code}, {3'b0, pat});
   endtask

   initial begin
      @(negedge clk);
      t_capture(5'b10110);
      t_release(5'b10110, 5'b01001);
      t_reg_source(5'b10110);
      t_ctrl_bits();
      t_recapture(5'b01101);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule